// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the 64-bit control registers a processor core consults in privileged mode. They sit behind one indexed port with a read strobe, a write strobe and a write-suppress input. Every index carries its own write rule. Some keep only a field of the written word. Some clear to zero whenever they are written. Some refuse writes, and some refuse reads. One register, the cycle counter, combines stored bits with a live count when it is read. An access that breaks these rules, or that names an unmapped index, raises a one-cycle error flag and changes nothing.

The core also sees three values straight from the bank. These are the current interrupt priority level, the two-bit processor mode and the exception return address. A synchronous reset clears the bank and then loads three values: a base address taken from a parameter, the constant 0x6 in the mode-control register, and the CPU identifier in the highest scratch slot.

The index map is 6 bits wide. Scratch registers occupy indices 0 to NUM_SCRATCH-1 (default 8). The named registers start at index 0x20:

| Index | Register |
|---|---|
| 0x20 | base |
| 0x21 | mode control |
| 0x22 | exception return |
| 0x23 | trap request |
| 0x24 | trap enable |
| 0x25 | priority level |
| 0x26 | instruction mode |
| 0x27 | data mode |
| 0x28 | alternate mode |
| 0x29 | software interrupt |
| 0x2A | control/status |
| 0x2B | instruction page-table base |
| 0x2C | data page-table base |
| 0x2D | exception summary |
| 0x2E | exception mask |
| 0x2F | cycle counter |
| 0x30 | identifier |
| 0x31 | flush command |

Every other index is unmapped.

Top module: `priv_csr_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every register clears. Then index 0x20 takes parameter BASE_RESET, index 0x21 takes 0x6, and scratch index NUM_SCRATCH-1 takes cpu_id_i, zero-extended.
- R2: rdata_o is registered. It carries the value selected by a read strobe one cycle after that strobe and holds between reads. The scratch registers, 0x20 and 0x21 store all 64 written bits.
- R3: A write to 0x22 stores the data with bit 1 forced to 0, and exc_ret_o shows that register from the next cycle.
- R4: The trap request register (0x23) and trap enable register (0x24) keep write bits 3:0. The priority level register (0x25) keeps bits 4:0, and ipl_o shows bits 4:0 of 0x25 from the next cycle.
- R5: The mode registers 0x26, 0x27 and 0x28 keep write bits 4:3 (mask 0x18). mode_o shows bits 4:3 of 0x26.
- R6: The software interrupt register (0x29) keeps mask 0x7fff0. The control/status register (0x2A) keeps mask 0xff_ffff_0300. The page-table bases (0x2B, 0x2C) keep bits 63:30.
- R7: A write to 0x2D or 0x2E clears that register to zero, whatever the data.
- R8: A read of 0x2F returns bits 63:32 of the stored value above the cyc_lo_i value present at the read strobe. A write to 0x2F stores all 64 bits.
- R9: Four kinds of access are illegal: a write to 0x30, a read of 0x28 or 0x31, and any access to an unmapped index. An illegal access raises err_o for exactly the next cycle and leaves every register unchanged. A read that raises the error returns zero. Index 0x30 always reads zero.
- R10: While wr_block_i is high, a write strobe changes no register and raises no error.
- R11: A read and a write to the same index in one cycle return the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id_i | input | ID_W | CPU identifier, loaded at reset |
| cyc_lo_i | input | 32 | Free-running cycle count, low half |
| idx_i | input | 6 | Register index |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_block_i | input | 1 | Write suppression |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| err_o | output | 1 | Illegal-access pulse |
| ipl_o | output | 5 | Current interrupt priority level |
| mode_o | output | 2 | Current processor mode |
| exc_ret_o | output | 64 | Exception return address |

## Verification
A read and a write can land in the same cycle, and the bench provokes this by strobing both at one index. It does this on a scratch slot, on the priority level register and on the cycle counter. It then checks two things: that the read returns the value held before the write, and that a following read shows the masked new value. A suppressed write can also coincide with a read. Here the bench checks that the read is served and that the register, read back at the port, keeps its old contents.

// File: rtl/priv_csr_pkg.sv
// Shared constants, the named-register index map and the per-index access
// attributes of the privileged control register file.
// Assumes a 6-bit index space with scratch slots at the bottom and the
// named registers starting at NAMED_BASE.
package priv_csr_pkg;

    localparam int IDX_W  = 6;
    localparam int DATA_W = 64;

    localparam logic [IDX_W-1:0] NAMED_BASE = 6'h20;

    // Offsets of the named registers above NAMED_BASE
    localparam int N_BASE  = 0;
    localparam int N_PCTL  = 1;
    localparam int N_ERET  = 2;
    localparam int N_ASTQ  = 3;
    localparam int N_ASTE  = 4;
    localparam int N_IPL   = 5;
    localparam int N_IMODE = 6;
    localparam int N_DMODE = 7;
    localparam int N_ALT   = 8;
    localparam int N_SWI   = 9;
    localparam int N_CSR   = 10;
    localparam int N_IPTB  = 11;
    localparam int N_DPTB  = 12;
    localparam int N_XSUM  = 13;
    localparam int N_XMSK  = 14;
    localparam int N_CYC   = 15;
    localparam int N_INTID = 16;
    localparam int N_FLUSH = 17;
    localparam int NUM_NAMED = 18;

    localparam logic [DATA_W-1:0] PCTL_RESET = 64'h6;

    // Access attributes of one index
    typedef struct packed {
        logic              rd_ok;
        logic              wr_ok;
        logic              clr;
        logic [DATA_W-1:0] mask;
    } attr_t;

    // Attributes of index idx for a bank with nscr scratch slots
    function automatic attr_t attr_of(input logic [IDX_W-1:0] idx, input int nscr);
        attr_t a;
        a.rd_ok = 1'b0;
        a.wr_ok = 1'b0;
        a.clr   = 1'b0;
        a.mask  = '1;
        if (!idx[IDX_W-1] && (int'(idx) < nscr)) begin
            a.rd_ok = 1'b1;
            a.wr_ok = 1'b1;
        end else if (idx[IDX_W-1]) begin
            a.rd_ok = 1'b1;
            a.wr_ok = 1'b1;
            case (int'(idx[IDX_W-2:0]))
                N_BASE, N_PCTL, N_CYC, N_FLUSH: a.mask = '1;
                N_ERET:                 a.mask = ~64'h2;
                N_ASTQ, N_ASTE:         a.mask = 64'hf;
                N_IPL:                  a.mask = 64'h1f;
                N_IMODE, N_DMODE, N_ALT: a.mask = 64'h18;
                N_SWI:                  a.mask = 64'h7fff0;
                N_CSR:                  a.mask = 64'h0000_00ff_ffff_0300;
                N_IPTB, N_DPTB:         a.mask = 64'hffff_ffff_c000_0000;
                N_XSUM, N_XMSK:         a.clr  = 1'b1;
                N_INTID:                a.wr_ok = 1'b0;
                default: begin
                    a.rd_ok = 1'b0;
                    a.wr_ok = 1'b0;
                end
            endcase
            if (int'(idx[IDX_W-2:0]) == N_ALT || int'(idx[IDX_W-2:0]) == N_FLUSH)
                a.rd_ok = 1'b0;
        end
        return a;
    endfunction

endpackage

// File: rtl/priv_csr_decode.sv
// Index decoder: turns the register index into access attributes and
// one-hot selects for the scratch slots and the named registers.
// Assumes NUM_SCRATCH <= 32 so scratch slots never reach NAMED_BASE.
module priv_csr_decode
    import priv_csr_pkg::*;
#(
    parameter int NUM_SCRATCH = 8
) (
    input  logic [IDX_W-1:0]     idx_i,
    output attr_t                attr_o,
    output logic [NUM_SCRATCH-1:0] scr_sel_o,
    output logic [NUM_NAMED-1:0] named_sel_o
);

    // Attribute lookup for the presented index
    always_comb attr_o = attr_of(idx_i, NUM_SCRATCH);

    // One-hot select per scratch slot
    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr_sel
        assign scr_sel_o[g] = (idx_i == IDX_W'(g));
    end

    // One-hot select per named register
    for (genvar g = 0; g < NUM_NAMED; g++) begin : g_named_sel
        assign named_sel_o[g] = (idx_i == (NAMED_BASE + IDX_W'(g)));
    end

endmodule

// File: rtl/priv_csr_scratch.sv
// Scratch register array: plain 64-bit storage per slot with a write
// enable each. Assumes the write value is already masked by the caller.
// The highest slot loads the CPU identifier at reset.
module priv_csr_scratch
    import priv_csr_pkg::*;
#(
    parameter int NUM_SCRATCH = 8,
    parameter int ID_W        = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ID_W-1:0]                     cpu_id_i,
    input  logic [NUM_SCRATCH-1:0]              we_i,
    input  logic [DATA_W-1:0]                   wval_i,
    output logic [NUM_SCRATCH-1:0][DATA_W-1:0]  q_o
);

    localparam int ID_SLOT = NUM_SCRATCH - 1;

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_slot
        if (g == ID_SLOT) begin : g_id
            // Identifier slot: loads cpu_id at reset, else plain storage
            always_ff @(posedge clk) begin
                if (!rst_n)      q_o[g] <= DATA_W'(cpu_id_i);
                else if (we_i[g]) q_o[g] <= wval_i;
            end
        end else begin : g_plain
            // Plain slot: clears at reset
            always_ff @(posedge clk) begin
                if (!rst_n)      q_o[g] <= '0;
                else if (we_i[g]) q_o[g] <= wval_i;
            end
        end
    end

endmodule

// File: rtl/priv_csr_named.sv
// Named control registers: one 64-bit register per named index, each
// with its own reset value. Masking and clear-on-write are applied by the
// caller; this module only stores what it is given.
module priv_csr_named
    import priv_csr_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_RESET = 64'h0000_0000_0001_0000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_NAMED-1:0]              we_i,
    input  logic [DATA_W-1:0]                 wval_i,
    output logic [NUM_NAMED-1:0][DATA_W-1:0]  q_o
);

    for (genvar g = 0; g < NUM_NAMED; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL =
            (g == N_BASE) ? BASE_RESET :
            (g == N_PCTL) ? PCTL_RESET : '0;
        // Storage for one named register
        always_ff @(posedge clk) begin
            if (!rst_n)       q_o[g] <= RST_VAL;
            else if (we_i[g]) q_o[g] <= wval_i;
        end
    end

endmodule

// File: rtl/priv_csr_bank.sv
// Privileged control register file top. Applies per-index write rules,
// legality checks and write suppression, muxes the read value (with the
// composite cycle-counter view), registers read data and the error pulse,
// and exposes priority level, mode and exception return to the core.
// Assumes at most one index per cycle; a read and a write in the same
// cycle target that one index.
module priv_csr_bank
    import priv_csr_pkg::*;
#(
    parameter int                NUM_SCRATCH = 8,
    parameter int                ID_W        = 8,
    parameter logic [DATA_W-1:0] BASE_RESET  = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cpu_id_i,
    input  logic [31:0]       cyc_lo_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic              wr_block_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic [4:0]        ipl_o,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] exc_ret_o
);

    attr_t                               attr;
    logic [NUM_SCRATCH-1:0]              scr_sel;
    logic [NUM_NAMED-1:0]                named_sel;
    logic [NUM_SCRATCH-1:0][DATA_W-1:0]  scr_q;
    logic [NUM_NAMED-1:0][DATA_W-1:0]    named_q;
    logic                                wr_try;
    logic                                wr_go;
    logic                                rd_go;
    logic                                err_d;
    logic [DATA_W-1:0]                   wval;
    logic [DATA_W-1:0]                   rd_val;

    priv_csr_decode #(
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_dec (
        .idx_i       (idx_i),
        .attr_o      (attr),
        .scr_sel_o   (scr_sel),
        .named_sel_o (named_sel)
    );

    // Write qualification: suppressed writes are dropped entirely
    always_comb begin
        wr_try = wr_en_i && !wr_block_i;
        wr_go  = wr_try && attr.wr_ok;
        rd_go  = rd_en_i && attr.rd_ok;
        err_d  = (rd_en_i && !attr.rd_ok) || (wr_try && !attr.wr_ok);
        wval   = attr.clr ? '0 : (wdata_i & attr.mask);
    end

    priv_csr_scratch #(
        .NUM_SCRATCH (NUM_SCRATCH),
        .ID_W        (ID_W)
    ) u_scr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_id_i (cpu_id_i),
        .we_i     (scr_sel & {NUM_SCRATCH{wr_go}}),
        .wval_i   (wval),
        .q_o      (scr_q)
    );

    priv_csr_named #(
        .BASE_RESET (BASE_RESET)
    ) u_named (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (named_sel & {NUM_NAMED{wr_go}}),
        .wval_i (wval),
        .q_o    (named_q)
    );

    // AND-OR read mux over all slots; cycle counter reads composite
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_SCRATCH; k++) begin
            if (scr_sel[k]) rd_val = rd_val | scr_q[k];
        end
        for (int k = 0; k < NUM_NAMED; k++) begin
            if (named_sel[k]) begin
                if (k == N_CYC) rd_val = rd_val | {named_q[k][63:32], cyc_lo_i};
                else            rd_val = rd_val | named_q[k];
            end
        end
    end

    // Registered read data: updated on every read strobe, zero if illegal
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_go ? rd_val : '0;
    end

    // Registered one-cycle error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= err_d;
    end

    // Direct views for the core
    assign ipl_o     = named_q[N_IPL][4:0];
    assign mode_o    = named_q[N_IMODE][4:3];
    assign exc_ret_o = named_q[N_ERET];

endmodule

// File: rtl/priv_csr_chk.sv
// Assertion checker for priv_csr_bank, attached with bind below.
// Relates port activity to the core-facing views one cycle later.
module priv_csr_chk
    import priv_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  idx_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic              wr_block_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              err_o,
    input logic [4:0]        ipl_o,
    input logic [1:0]        mode_o,
    input logic [DATA_W-1:0] exc_ret_o
);

    localparam logic [IDX_W-1:0] I_ERET  = NAMED_BASE + IDX_W'(N_ERET);
    localparam logic [IDX_W-1:0] I_IPL   = NAMED_BASE + IDX_W'(N_IPL);
    localparam logic [IDX_W-1:0] I_IMODE = NAMED_BASE + IDX_W'(N_IMODE);

    p_eret_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_block_i && idx_i == I_ERET) |=>
            (exc_ret_o == ($past(wdata_i) & ~64'h2)));

    p_ipl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_block_i && idx_i == I_IPL) |=>
            (ipl_o == $past(wdata_i[4:0])));

    p_mode_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_block_i && idx_i == I_IMODE) |=>
            (mode_o == $past(wdata_i[4:3])));

    p_err_rdzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i) |=> (!err_o || rdata_o == '0));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i && !wr_en_i) |=> !err_o);

    p_block_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block_i |=> ($stable(ipl_o) && $stable(mode_o) && $stable(exc_ret_o)));

endmodule

bind priv_csr_bank priv_csr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_i      (idx_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_block_i (wr_block_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .ipl_o      (ipl_o),
    .mode_o     (mode_o),
    .exc_ret_o  (exc_ret_o)
);

// File: tb/tb_priv_csr_bank.sv
`timescale 1ns/1ps
module tb_priv_csr_bank;

    localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;
    localparam logic [7:0]  CPUID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_id = CPUID;
    logic [31:0] cyc = 32'h1234_5678;
    logic [5:0]  idx = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, wr_block = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        err;
    logic [4:0]  ipl;
    logic [1:0]  mode;
    logic [63:0] eret;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [63:0] model [64];

    always #10 clk = ~clk;

    priv_csr_bank dut (
        .clk(clk), .rst_n(rst_n), .cpu_id_i(cpu_id), .cyc_lo_i(cyc),
        .idx_i(idx), .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_block_i(wr_block),
        .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .ipl_o(ipl),
        .mode_o(mode), .exc_ret_o(eret)
    );

    // Legality and masks taken from the requirement text
    function automatic bit wr_legal(int i);
        return (i < 8) || (i >= 32 && i <= 49 && i != 48);
    endfunction
    function automatic bit rd_legal(int i);
        return (i < 8) || (i >= 32 && i <= 49 && i != 40 && i != 49);
    endfunction
    function automatic logic [63:0] wmask(int i);
        case (i)
            34: return ~64'h2;
            35, 36: return 64'hf;
            37: return 64'h1f;
            38, 39, 40: return 64'h18;
            41: return 64'h7fff0;
            42: return 64'h0000_00ff_ffff_0300;
            43, 44: return 64'hffff_ffff_c000_0000;
            45, 46: return 64'h0;
            default: return '1;
        endcase
    endfunction
    function automatic string tag(int i);
        if (i < 8 || i == 32 || i == 33) return "R2";
        if (i == 34) return "R3";
        if (i >= 35 && i <= 37) return "R4";
        if (i >= 38 && i <= 40) return "R5";
        if (i >= 41 && i <= 44) return "R6";
        if (i == 45 || i == 46) return "R7";
        if (i == 47) return "R8";
        return "R9";
    endfunction
    function automatic logic [63:0] exp_read(int i);
        if (!rd_legal(i)) return '0;
        if (i == 47) return {model[i][63:32], cyc};
        return model[i];
    endfunction

    task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic op(input logic r, input logic w, input logic b, input int i, input logic [63:0] d);
        rd_en = r; wr_en = w; wr_block = b; idx = 6'(i); wdata = d;
        @(posedge clk);
        @(negedge clk);
        rd_en = 0; wr_en = 0; wr_block = 0;
    endtask

    task automatic model_write(input int i, input logic [63:0] d);
        if (wr_legal(i)) model[i] = d & wmask(i);
    endtask

    task automatic read_chk(input int i, input string t);
        logic [63:0] e;
        e = exp_read(i);
        op(1, 0, 0, i, '0);
        chk(t, $sformatf("read idx %0d", i), rdata, e);
        chk(t, $sformatf("err after read idx %0d", i), 64'(err), 64'(!rd_legal(i)));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        model[32] = BASE; model[33] = 64'h6; model[7] = 64'(CPUID);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "err after reset", 64'(err), 64'h0);
        chk("R1", "ipl after reset", 64'(ipl), 64'h0);
        // Reset sweep: every index read back
        for (int i = 0; i < 64; i++) read_chk(i, rd_legal(i) ? "R1" : "R9");

        // Pattern sweeps: write then read every index
        for (int p = 0; p < 3; p++) begin
            logic [63:0] pat;
            pat = (p == 0) ? '1 : (p == 1) ? 64'hA5A5_5A5A_C3C3_3C3C : 64'h5A5A_A5A5_3C3C_C3C3;
            for (int i = 0; i < 64; i++) begin
                op(0, 1, 0, i, pat ^ 64'(i));
                chk(tag(i), $sformatf("err after write idx %0d", i), 64'(err), 64'(!wr_legal(i)));
                model_write(i, pat ^ 64'(i));
                read_chk(i, tag(i));
            end
            chk("R3", "exc_ret_o", eret, model[34]);
            chk("R4", "ipl_o", 64'(ipl), 64'(model[37][4:0]));
            chk("R5", "mode_o", 64'(mode), 64'(model[38][4:3]));
        end

        // R11: simultaneous read and write of one index
        begin
            int lst [3] = '{2, 37, 47};
            foreach (lst[k]) begin
                logic [63:0] old_v;
                old_v = exp_read(lst[k]);
                op(1, 1, 0, lst[k], 64'hFEED_0000_0000_0017 + 64'(k));
                chk("R11", $sformatf("same-cycle read idx %0d returns old", lst[k]), rdata, old_v);
                model_write(lst[k], 64'hFEED_0000_0000_0017 + 64'(k));
                read_chk(lst[k], "R11");
            end
        end

        // R10: suppressed writes, one alongside a read
        op(0, 1, 1, 37, 64'h3);
        chk("R10", "no err on blocked write", 64'(err), 64'h0);
        chk("R10", "ipl_o unchanged", 64'(ipl), 64'(model[37][4:0]));
        op(1, 1, 1, 3, 64'h1111);
        chk("R10", "read served during blocked write", rdata, model[3]);
        read_chk(3, "R10");
        op(0, 1, 1, 48, 64'h1);
        chk("R10", "blocked illegal write raises no err", 64'(err), 64'h0);

        // R9: illegal write leaves state, pulse lasts one cycle
        op(0, 1, 0, 48, 64'hFFFF);
        chk("R9", "err on write to identifier", 64'(err), 64'h1);
        op(0, 0, 0, 0, '0);
        chk("R9", "err clears after idle", 64'(err), 64'h0);
        read_chk(48, "R9");
        op(0, 1, 0, 20, 64'hABCD);
        chk("R9", "err on unmapped write", 64'(err), 64'h1);
        for (int i = 0; i < 8; i++) read_chk(i, "R9");

        // R7: clear-on-write after a stored nonzero is impossible; confirm zero
        op(0, 1, 0, 45, '1);
        read_chk(45, "R7");

        // R8: live count changes
        cyc = 32'h0BAD_F00D;
        read_chk(47, "R8");
        cyc = 32'hFFFF_FFFF;
        op(0, 1, 0, 47, 64'h8765_4321_0000_0000);
        model_write(47, 64'h8765_4321_0000_0000);
        read_chk(47, "R8");

        // R1 again: reset mid-run restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model[i] = '0;
        model[32] = BASE; model[33] = 64'h6; model[7] = 64'(CPUID);
        @(negedge clk);
        for (int i = 0; i < 64; i++) if (rd_legal(i)) read_chk(i, "R1");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule